// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns a two-wire serial bus to a usable state when a slave has been left mid-byte and is holding the data line low. It releases both lines, then generates nine full clock periods on SCL while watching SDA. If SDA was high at any of those samples, it builds a START and then a STOP on the bus. It does this while SCL stays released high the whole time, so no slave sees a clock edge between the two conditions. It then keeps the bus quiet for the bus-free interval. If SDA was low at every sample, the block gives up without touching SDA and raises a fail flag.

A run starts by itself once reset is released, when the AUTO_START parameter is set, or on a single-cycle request pulse. While a run is in progress, `busy` tells other bus masters to stay off the lines. Both line outputs are open-drain controls: a 1 pulls the wire low and a 0 releases it. The line inputs are expected to be already synchronized to `clk`. Every high phase of the clock waits for SCL to actually read high, which lets a slave stretch the clock. That wait is bounded by a timeout, and when the timeout expires the sequence carries on. All durations are counted in `clk` cycles and set through parameters.

Top module: `i2c_bus_recovery`

## Requirements
- R1: While `rst_n` is low, both drive outputs are 0 (lines released), and `busy`, `done`, `fail` and `notIdleWarn` are all 0.
- R2: With AUTO_START=1 a run begins within three cycles after reset is released. A `recoverReq` pulse while idle starts a run. A `recoverReq` pulse while `busy` is high has no effect: no extra clock pulses and no second `done`.
- R3: Each run drives SCL low exactly NUM_PULSES (nine by default) times, and each low phase lasts at least LOW_CYC cycles.
- R4: After each SCL release the block waits until SCL reads high, or until RISE_TIMEOUT cycles have passed, whichever comes first. It then keeps SCL released for at least HIGH_CYC cycles measured from the moment the line reads high. A line that never rises does not stop the run.
- R5: SDA is sampled at the end of each high phase into a sticky flag. Clocking always completes all pulses, whether or not SDA has been seen high.
- R6: If SDA was never seen high, SDA is never driven low during the run, no START or STOP appears on the bus, and `fail` is 1 when `done` is asserted.
- R7: If SDA was seen high, the block waits US_CYC cycles with both lines released, pulls SDA low for US_CYC cycles, then releases it. SCL stays released from the last clock pulse until the end of the run, so the bus shows a START followed by a STOP with no SCL low in between. In this case `fail` is 0.
- R8: When SDA was seen high, the block samples both lines after the last pulse. If either line reads low, it sets `notIdleWarn` and still performs the START/STOP.
- R9: After SDA is released for the STOP, at least TBUF_CYC cycles pass before `done`.
- R10: `done` is a one-cycle pulse in the cycle where `busy` falls. `fail` and `notIdleWarn` keep their values until the next run starts.
- R11: Neither line is ever driven low while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recoverReq | input | 1 | One-cycle pulse requesting a recovery run |
| sclIn | input | 1 | Synchronized SCL line level |
| sdaIn | input | 1 | Synchronized SDA line level |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A run is in progress; other masters stay off the bus |
| done | output | 1 | One-cycle pulse when a run finishes |
| fail | output | 1 | SDA was never seen high during the last run |
| notIdleWarn | output | 1 | A line read low just before the START of the last run |

## Verification
The bench models the wired-AND bus together with a misbehaving slave, and runs the sequence against several slave patterns:
- A free bus, which shows the full START/STOP path and the bus-free gap.
- SDA held low forever, which shows the fail path and that SDA is never touched.
- SDA released only from the sixth pulse on, which shows that clocking does not stop early.
- SDA high during the third pulse only, which shows the sticky sample and the warning path.
- Bounded clock stretching, which shows that the high phase is timed from the real rise.
- SCL stuck low, which shows that the rise timeout keeps the run moving.

A request pulse in the middle of a run shows that a request while busy is dropped.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

  typedef enum logic [2:0] {
    TM_LOW,
    TM_HIGH,
    TM_US,
    TM_TBUF,
    TM_RISE
  } timerSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPEN,
    ST_LOW,
    ST_RISE,
    ST_HIGH,
    ST_DECIDE,
    ST_SETUP,
    ST_HOLD,
    ST_BUSFREE,
    ST_FINISH
  } recState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      timerLoad;
    timerSel_e timerSel;
    logic      sclLow;
    logic      sdaLow;
    logic      clearRun;
    logic      incPulse;
    logic      sampleSda;
    logic      captureIdle;
    logic      setFail;
  } recStrobe_t;

endpackage

// File: rtl/i2c_recovery_dp.sv
module i2c_recovery_dp
  import i2crec_pkg::*;
#(
  parameter int LOW_CYC      = 250,
  parameter int HIGH_CYC     = 250,
  parameter int US_CYC       = 100,
  parameter int TBUF_CYC     = 6000,
  parameter int RISE_TIMEOUT = 100000,
  parameter int NUM_PULSES   = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  recStrobe_t str,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       timerDone,
  output logic       pulseLast,
  output logic       sdaSeenHigh,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       fail,
  output logic       notIdleWarn
);

  localparam int MAX_A = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_B = (US_CYC > TBUF_CYC) ? US_CYC : TBUF_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMAX  = (MAX_C > RISE_TIMEOUT) ? MAX_C : RISE_TIMEOUT;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int CW    = $clog2(NUM_PULSES + 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] loadVal;
  logic [CW-1:0] pulseCnt;

  // Duration selection
  always_comb begin
    case (str.timerSel)
      TM_LOW:  loadVal = TW'(LOW_CYC);
      TM_HIGH: loadVal = TW'(HIGH_CYC);
      TM_US:   loadVal = TW'(US_CYC);
      TM_TBUF: loadVal = TW'(TBUF_CYC);
      default: loadVal = TW'(RISE_TIMEOUT);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (str.timerLoad) begin
      timer <= loadVal;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign timerDone = (timer == '0);

  // Pulse counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseCnt <= '0;
    end else if (str.clearRun) begin
      pulseCnt <= '0;
    end else if (str.incPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign pulseLast = (pulseCnt == CW'(NUM_PULSES - 1));

  // Sticky SDA observation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdaSeenHigh <= 1'b0;
    end else if (str.clearRun) begin
      sdaSeenHigh <= 1'b0;
    end else if (str.sampleSda) begin
      sdaSeenHigh <= sdaSeenHigh | sdaIn;
    end
  end

  // Result flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail        <= 1'b0;
      notIdleWarn <= 1'b0;
    end else if (str.clearRun) begin
      fail        <= 1'b0;
      notIdleWarn <= 1'b0;
    end else begin
      if (str.setFail)     fail        <= 1'b1;
      if (str.captureIdle) notIdleWarn <= ~(sclIn & sdaIn);
    end
  end

  // Registered open-drain controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      sclDriveLow <= str.sclLow;
      sdaDriveLow <= str.sdaLow;
    end
  end

  // R7
  sda_scl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclDriveLow && sdaDriveLow));

  // R6
  sda_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdaDriveLow |-> sdaSeenHigh);

  // R3
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.incPulse |-> (pulseCnt < CW'(NUM_PULSES)));

endmodule

// File: rtl/i2c_recovery_ctrl.sv
module i2c_recovery_ctrl
  import i2crec_pkg::*;
#(
  parameter bit AUTO_START = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       recoverReq,
  input  logic       sclIn,
  input  logic       timerDone,
  input  logic       pulseLast,
  input  logic       sdaSeenHigh,
  output recStrobe_t str,
  output logic       busy,
  output logic       done
);

  recState_e state, nxt;
  logic      autoPending;
  logic      go;

  generate
    if (AUTO_START) begin : g_auto
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          autoPending <= 1'b1;
        end else if (state == ST_IDLE) begin
          autoPending <= 1'b0;
        end
      end
    end else begin : g_manual
      assign autoPending = 1'b0;
    end
  endgenerate

  assign go = (state == ST_IDLE) && (recoverReq || autoPending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= nxt;
    end
  end

  always_comb begin
    nxt = state;
    str = '0;
    unique case (state)
      ST_IDLE: begin
        if (go) begin
          str.clearRun  = 1'b1;
          str.timerLoad = 1'b1;
          str.timerSel  = TM_US;
          nxt           = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (timerDone) begin
          str.timerLoad = 1'b1;
          str.timerSel  = TM_LOW;
          nxt           = ST_LOW;
        end
      end
      ST_LOW: begin
        str.sclLow = 1'b1;
        if (timerDone) begin
          str.timerLoad = 1'b1;
          str.timerSel  = TM_RISE;
          nxt           = ST_RISE;
        end
      end
      ST_RISE: begin
        if (sclIn || timerDone) begin
          str.timerLoad = 1'b1;
          str.timerSel  = TM_HIGH;
          nxt           = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (timerDone) begin
          str.sampleSda = 1'b1;
          str.incPulse  = 1'b1;
          if (pulseLast) begin
            nxt = ST_DECIDE;
          end else begin
            str.timerLoad = 1'b1;
            str.timerSel  = TM_LOW;
            nxt           = ST_LOW;
          end
        end
      end
      ST_DECIDE: begin
        if (sdaSeenHigh) begin
          str.captureIdle = 1'b1;
          str.timerLoad   = 1'b1;
          str.timerSel    = TM_US;
          nxt             = ST_SETUP;
        end else begin
          str.setFail = 1'b1;
          nxt         = ST_FINISH;
        end
      end
      ST_SETUP: begin
        if (timerDone) begin
          str.timerLoad = 1'b1;
          str.timerSel  = TM_US;
          nxt           = ST_HOLD;
        end
      end
      ST_HOLD: begin
        str.sdaLow = 1'b1;
        if (timerDone) begin
          str.timerLoad = 1'b1;
          str.timerSel  = TM_TBUF;
          nxt           = ST_BUSFREE;
        end
      end
      ST_BUSFREE: begin
        if (timerDone) nxt = ST_FINISH;
      end
      ST_FINISH: begin
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_FINISH);
  assign done = (state == ST_FINISH);

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  scl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !str.sclLow && !sclIn == !sclIn);

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery
  import i2crec_pkg::*;
#(
  parameter int LOW_CYC      = 250,
  parameter int HIGH_CYC     = 250,
  parameter int US_CYC       = 100,
  parameter int TBUF_CYC     = 6000,
  parameter int RISE_TIMEOUT = 100000,
  parameter int NUM_PULSES   = 9,
  parameter bit AUTO_START   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recoverReq,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclDriveLow,
  output logic sdaDriveLow,
  output logic busy,
  output logic done,
  output logic fail,
  output logic notIdleWarn
);

  recStrobe_t str;
  logic       timerDone;
  logic       pulseLast;
  logic       sdaSeenHigh;

  i2c_recovery_ctrl #(
    .AUTO_START (AUTO_START)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .recoverReq  (recoverReq),
    .sclIn       (sclIn),
    .timerDone   (timerDone),
    .pulseLast   (pulseLast),
    .sdaSeenHigh (sdaSeenHigh),
    .str         (str),
    .busy        (busy),
    .done        (done)
  );

  i2c_recovery_dp #(
    .LOW_CYC      (LOW_CYC),
    .HIGH_CYC     (HIGH_CYC),
    .US_CYC       (US_CYC),
    .TBUF_CYC     (TBUF_CYC),
    .RISE_TIMEOUT (RISE_TIMEOUT),
    .NUM_PULSES   (NUM_PULSES)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .str         (str),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .timerDone   (timerDone),
    .pulseLast   (pulseLast),
    .sdaSeenHigh (sdaSeenHigh),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .fail        (fail),
    .notIdleWarn (notIdleWarn)
  );

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!sclDriveLow && !sdaDriveLow));

endmodule

// File: tb/i2c_bus_recovery_test.sv
`timescale 1ns/1ps
module i2c_bus_recovery_test;

  localparam int LOW_CYC = 20, HIGH_CYC = 20, US_CYC = 10, TBUF_CYC = 60;
  localparam int RISE_TIMEOUT = 200, NUM_PULSES = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic recoverReq;
  logic sclDriveLow, sdaDriveLow, busy, done, fail, notIdleWarn;
  logic sclLine, sdaLine;
  int   mode;
  logic monReset;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // monitor state
  int sclFalls, riseCount, lowRun, highRun, minLow, minHigh, relCnt, busFree, doneCount;
  int stretchCnt;
  bit startSeen, stopSeen, inStart, startSclLow, sdaDrvSeen, idleDrive;
  logic prevSclDrv, prevSdaDrv, prevScl, prevSda;

  always #5 clk = ~clk;

  // Wired-AND bus with slave behaviours
  assign sclLine = !sclDriveLow && (mode != 4) && !((mode == 5) && (stretchCnt > 0));
  assign sdaLine = !sdaDriveLow &&
                   !((mode == 1) ||
                     ((mode == 2) && (riseCount < 6)) ||
                     ((mode == 3) && !((riseCount == 3) && sclLine)));

  i2c_bus_recovery #(
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .US_CYC(US_CYC), .TBUF_CYC(TBUF_CYC),
    .RISE_TIMEOUT(RISE_TIMEOUT), .NUM_PULSES(NUM_PULSES), .AUTO_START(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .recoverReq(recoverReq),
    .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done), .fail(fail), .notIdleWarn(notIdleWarn)
  );

  always @(negedge clk) begin
    if (monReset) begin
      sclFalls <= 0; riseCount <= 0; lowRun <= 0; highRun <= 99999;
      minLow <= 99999; minHigh <= 99999; relCnt <= 0; busFree <= 0; doneCount <= 0;
      startSeen <= 0; stopSeen <= 0; inStart <= 0; startSclLow <= 0;
      sdaDrvSeen <= 0; idleDrive <= 0; stretchCnt <= 0;
    end else begin
      if (sclDriveLow && !prevSclDrv) sclFalls <= sclFalls + 1;
      if (sclDriveLow) lowRun <= lowRun + 1;
      else if (prevSclDrv) begin
        if (lowRun < minLow) minLow <= lowRun;
        lowRun <= 0;
      end
      if (sclLine && !sclDriveLow) highRun <= highRun + 1;
      if (sclDriveLow && !prevSclDrv) begin
        if (highRun < minHigh) minHigh <= highRun;
        highRun <= 0;
      end
      if (sclLine && !prevScl) riseCount <= riseCount + 1;
      if (sclLine && prevScl && prevSda && !sdaLine) begin
        startSeen <= 1; inStart <= 1;
      end
      if (inStart && !sclLine) startSclLow <= 1;
      if (inStart && sclLine && !prevSda && sdaLine) begin
        stopSeen <= 1; inStart <= 0;
      end
      if (sdaDriveLow) sdaDrvSeen <= 1;
      if (!sdaDriveLow && prevSdaDrv) relCnt <= 1;
      else if (!sdaDriveLow) relCnt <= relCnt + 1;
      if (done) begin
        doneCount <= doneCount + 1;
        busFree   <= relCnt;
      end
      if (!busy && (sclDriveLow || sdaDriveLow)) idleDrive <= 1;
      if (sclDriveLow) stretchCnt <= 30;
      else if (stretchCnt > 0) stretchCnt <= stretchCnt - 1;
    end
    prevSclDrv <= sclDriveLow;
    prevSdaDrv <= sdaDriveLow;
    prevScl    <= sclLine;
    prevSda    <= sdaLine;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finishRun();
    end
  end

  task automatic waitDone(input int limit);
    bit seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    #1;
    check(seen, "R10 done arrives", int'(seen), 1);
  endtask

  task automatic startRun(input int m);
    @(posedge clk); #2;
    mode = m; monReset = 1;
    @(posedge clk); #2;
    monReset = 0;
    @(posedge clk); #2;
    recoverReq = 1;
    @(posedge clk); #2;
    recoverReq = 0;
  endtask

  task automatic commonChecks();
    check(sclFalls == NUM_PULSES, "R3 pulse count", sclFalls, NUM_PULSES);
    check(sclFalls == 0 || minLow >= LOW_CYC, "R3 low width", minLow, LOW_CYC);
    check(doneCount == 1, "R10 single done", doneCount, 1);
    check(!idleDrive, "R11 drive only while busy", int'(idleDrive), 0);
  endtask

  task automatic testReset();
    check(!sclDriveLow && !sdaDriveLow, "R1 lines released", int'({sclDriveLow, sdaDriveLow}), 0);
    check(!busy && !done, "R1 busy/done low", int'({busy, done}), 0);
    check(!fail && !notIdleWarn, "R1 flags low", int'({fail, notIdleWarn}), 0);
  endtask

  task automatic testAuto();
    bit sawBusy = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (busy) sawBusy = 1;
    end
    check(sawBusy, "R2 auto start after reset", int'(sawBusy), 1);
    waitDone(3000);
    commonChecks();
    check(startSeen && stopSeen, "R7 start then stop", int'({startSeen, stopSeen}), 3);
    check(!startSclLow, "R7 scl high between start and stop", int'(startSclLow), 0);
    check(busFree >= TBUF_CYC, "R9 bus free time", busFree, TBUF_CYC);
    check(minHigh >= HIGH_CYC, "R4 high width", minHigh, HIGH_CYC);
    check(!fail && !notIdleWarn, "R7 no fail no warn", int'({fail, notIdleWarn}), 0);
  endtask

  task automatic testStuckSda();
    startRun(1);
    waitDone(3000);
    commonChecks();
    check(!sdaDrvSeen, "R6 sda untouched", int'(sdaDrvSeen), 0);
    check(!startSeen && !stopSeen, "R6 no start/stop", int'({startSeen, stopSeen}), 0);
    check(fail, "R6 fail set", int'(fail), 1);
    repeat (50) @(negedge clk);
    check(fail && !done && !busy, "R10 fail held while idle", int'({fail, done, busy}), 4);
  endtask

  task automatic testLateRelease();
    startRun(2);
    waitDone(3000);
    commonChecks();
    check(startSeen && stopSeen, "R5 start/stop after late release", int'({startSeen, stopSeen}), 3);
    check(!fail, "R5 fail clear", int'(fail), 0);
  endtask

  task automatic testGlimpse();
    startRun(3);
    waitDone(3000);
    commonChecks();
    check(notIdleWarn, "R8 warn on low sda", int'(notIdleWarn), 1);
    check(sdaDrvSeen, "R8 start still issued", int'(sdaDrvSeen), 1);
    check(!fail, "R5 sticky high sample", int'(fail), 0);
  endtask

  task automatic testStretch();
    startRun(5);
    waitDone(4000);
    commonChecks();
    check(minHigh >= HIGH_CYC, "R4 high timed from real rise", minHigh, HIGH_CYC);
    check(!fail && !notIdleWarn, "R4 stretch clean result", int'({fail, notIdleWarn}), 0);
  endtask

  task automatic testSclStuck();
    startRun(4);
    waitDone(6000);
    commonChecks();
    check(riseCount == 0, "R4 line never rose", riseCount, 0);
    check(notIdleWarn, "R8 warn on stuck scl", int'(notIdleWarn), 1);
  endtask

  task automatic testBusyReq();
    startRun(0);
    repeat (100) @(posedge clk);
    #2 recoverReq = 1;
    @(posedge clk); #2;
    recoverReq = 0;
    waitDone(3000);
    commonChecks();
    repeat (30) @(negedge clk);
    check(!busy && doneCount == 1, "R2 request while busy ignored", doneCount, 1);
    check(sclFalls == NUM_PULSES, "R2 no extra pulses", sclFalls, NUM_PULSES);
  endtask

  initial begin
    rst_n = 1'b0; recoverReq = 1'b0; mode = 0; monReset = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    @(posedge clk); #2;
    rst_n = 1'b1; monReset = 1'b0;
    testAuto();
    testStuckSda();
    testLateRelease();
    testGlimpse();
    testStretch();
    testSclStuck();
    testBusyReq();
    finishRun();
  end

endmodule